// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

The block captures a 4-bit binary code in a small storage stage and turns it into sixteen select lines, exactly one of which is driven to its active level. A strobe input controls the storage stage. While the strobe is high, the stage follows the code input on every clock edge. When the strobe is low, the last captured code is frozen and the lines keep decoding it.

A separate inhibit input drives every line to its inactive level at once, without a clock edge. It does not touch the stored code. The polarity is fixed at build time by the `ACTIVE_LOW` parameter. With the default value 0, the selected line is 1 and all other lines are 0. With the value 1, the selected line is 0 and all other lines are 1.

A synchronous reset clears the stored code to zero.

Top module: `latched_line_decoder`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, the stored code becomes 0. After that edge line 0 is the active line, provided `inhibit` is 0.
- R2: When `strobe` is 1 at a rising clock edge, the value on `code_in` is stored at that edge. The lines show the decode of that value from the edge onward.
- R3: When `strobe` is 0 at a rising clock edge, the stored code is unchanged, whatever value `code_in` has. The lines stay the same.
- R4: The stored code is an unsigned binary number, with `code_in[3]` as the most significant bit and `code_in[0]` as the least significant bit. Code n selects `lines[n]`. While `inhibit` is 0, exactly one line is at the active level.
- R5: With `ACTIVE_LOW` = 0, the selected line is 1 and the other fifteen lines are 0.
- R6: With `ACTIVE_LOW` = 1, the selected line is 0 and the other fifteen lines are 1.
- R7: While `inhibit` is 1, every line is at the inactive level: all 0 when `ACTIVE_LOW` = 0, and all 1 when `ACTIVE_LOW` = 1. This holds whatever the stored code and `code_in` are.
- R8: `inhibit` has no effect on the stored code. Loading and holding go on as R2 and R3 describe. When `inhibit` returns to 0, the lines show the decode of the code stored at that moment.
- R9: The lines depend combinationally on the stored code and on `inhibit`. A change of `inhibit` shows on `lines` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the code is stored on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the stored code |
| strobe | input | 1 | 1: the stage loads `code_in` each edge; 0: the stage holds |
| code_in | input | CODE_W (4) | Binary select code, most significant bit at the top |
| inhibit | input | 1 | 1: drives all lines to the inactive level |
| lines | output | 2**CODE_W (16) | Decoded select lines, polarity set by `ACTIVE_LOW` |

## Verification
The bound checker observes every cycle:
- loading while the strobe is high and holding while it is low;
- the clearing effect of reset;
- the idle pattern under inhibit;
- exactly one active line when inhibit is off, and that this line matches the stored code.

Only the directed scenarios can show three further behaviours:
- the full mapping of each of the sixteen codes to its line, in both polarities at once;
- that inhibit takes effect between clock edges;
- that a code stored while inhibit was high comes back intact when inhibit falls.

// File: rtl/lat_dec_pkg.sv
package lat_dec_pkg;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } pol_e;

  function automatic int unsigned line_count(input int unsigned code_w);
    return 32'd1 << code_w;
  endfunction

  function automatic pol_e pol_of(input int unsigned active_low);
    return (active_low != 0) ? POL_ACT_LOW : POL_ACT_HIGH;
  endfunction

endpackage

// File: rtl/code_hold.sv
module code_hold #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/line_decode.sv
module line_decode #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 16
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] onehot
);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign onehot[i] = (code == W'(i));
  end

endmodule

// File: rtl/out_stage.sv
module out_stage
  import lat_dec_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter pol_e        POL = POL_ACT_HIGH
) (
  input  logic [N-1:0] onehot,
  input  logic         inhibit,
  output logic [N-1:0] lines
);

  logic [N-1:0] gated;

  assign gated = inhibit ? '0 : onehot;

  if (POL == POL_ACT_LOW) begin : g_low
    assign lines = ~gated;
  end else begin : g_high
    assign lines = gated;
  end

endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
  import lat_dec_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned ACTIVE_LOW = 0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         strobe,
  input  logic [CODE_W-1:0]            code_in,
  input  logic                         inhibit,
  output logic [(1 << CODE_W)-1:0]     lines
);

  localparam int unsigned LINES = line_count(CODE_W);
  localparam pol_e        POL   = pol_of(ACTIVE_LOW);

  logic [CODE_W-1:0] held_code;
  logic [LINES-1:0]  raw_onehot;
  logic              load_evt;

  assign load_evt = strobe;

  code_hold #(.W(CODE_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (load_evt),
    .d    (code_in),
    .q    (held_code)
  );

  line_decode #(.W(CODE_W), .N(LINES)) u_dec (
    .code   (held_code),
    .onehot (raw_onehot)
  );

  out_stage #(.N(LINES), .POL(POL)) u_out (
    .onehot  (raw_onehot),
    .inhibit (inhibit),
    .lines   (lines)
  );

endmodule

// File: rtl/latched_line_decoder_chk.sv
module latched_line_decoder_chk #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned LINES      = 16,
  parameter int unsigned ACTIVE_LOW = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              inhibit,
  input logic [CODE_W-1:0] code_in,
  input logic [CODE_W-1:0] held_code,
  input logic [LINES-1:0]  lines
);

  localparam logic [LINES-1:0] IDLE = (ACTIVE_LOW != 0) ? '1 : '0;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (held_code == '0));

  // R2
  strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (held_code == $past(code_in)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(held_code));

  // R4
  single_active_chk: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> ($countones(lines ^ IDLE) == 1));

  // R4
  match_code_chk: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> (lines[held_code] != IDLE[0]));

  // R7
  inhibit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> (lines == IDLE));

endmodule

bind latched_line_decoder latched_line_decoder_chk #(
  .CODE_W     (CODE_W),
  .LINES      (LINES),
  .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe    (strobe),
  .inhibit   (inhibit),
  .code_in   (code_in),
  .held_code (held_code),
  .lines     (lines)
);

// File: tb/tb_latched_line_decoder.sv
module tb_latched_line_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [3:0]  code_in = 4'd0;
  logic        inhibit = 1'b0;
  logic [15:0] lines_h;
  logic [15:0] lines_l;

  int total = 0;
  int bad = 0;
  logic [3:0] model_code = 4'd0;

  always #2.5 clk = ~clk;

  latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(0)) dut (
    .clk(clk), .rst(rst), .strobe(strobe), .code_in(code_in),
    .inhibit(inhibit), .lines(lines_h)
  );

  latched_line_decoder #(.CODE_W(4), .ACTIVE_LOW(1)) dut_n (
    .clk(clk), .rst(rst), .strobe(strobe), .code_in(code_in),
    .inhibit(inhibit), .lines(lines_l)
  );

  function automatic logic [15:0] expect_lines(input logic [3:0] c, input logic inh,
                                               input logic low);
    logic [15:0] v;
    v = 16'd0;
    if (!inh) v[c] = 1'b1;
    return low ? ~v : v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req_h, input string req_l);
    check(req_h, lines_h, expect_lines(model_code, inhibit, 1'b0));
    check(req_l, lines_l, expect_lines(model_code, inhibit, 1'b1));
  endtask

  // drive at the falling edge, pass one rising edge, return at the next falling edge
  task automatic tick();
    if (rst) model_code = 4'd0;
    else if (strobe) model_code = code_in;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; strobe = 1'b1; code_in = 4'hA; inhibit = 1'b0;
    tick(); tick();
    rst = 1'b0; strobe = 1'b0;
    check("R1 R5", lines_h, 16'h0001);
    check("R1 R6", lines_l, 16'hFFFE);
  endtask

  task automatic t_sweep();
    strobe = 1'b1; inhibit = 1'b0;
    for (int n = 0; n < 16; n++) begin
      code_in = 4'(n);
      tick();
      check_both("R2 R4 R5", "R2 R4 R6");
      total++;
      if ($countones(lines_h) != 1 || $countones(~lines_l) != 1) begin
        bad++;
        $display("FAIL R4: actual=%0d/%0d expected=1/1",
                 $countones(lines_h), $countones(~lines_l));
      end
    end
  endtask

  task automatic t_hold();
    strobe = 1'b1; code_in = 4'd9; inhibit = 1'b0;
    tick();
    strobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      code_in = 4'(k * 5 + 2);
      tick();
      check("R3", lines_h, 16'h0200);
      check("R3", lines_l, 16'hFDFF);
    end
  endtask

  task automatic t_inhibit_hold();
    inhibit = 1'b1;
    #1;
    check("R9 R7", lines_h, 16'h0000);
    check("R9 R7", lines_l, 16'hFFFF);
    code_in = 4'd3;
    tick();
    check("R7", lines_h, 16'h0000);
    check("R7", lines_l, 16'hFFFF);
    inhibit = 1'b0;
    #1;
    check("R8 R9", lines_h, 16'h0200);
    check("R8 R9", lines_l, 16'hFDFF);
    @(negedge clk);
  endtask

  task automatic t_inhibit_load();
    inhibit = 1'b1; strobe = 1'b1; code_in = 4'd15;
    tick();
    check_both("R7", "R7");
    strobe = 1'b0; code_in = 4'd1;
    tick();
    inhibit = 1'b0;
    #1;
    check("R8", lines_h, 16'h8000);
    check("R8", lines_l, 16'h7FFF);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sweep();
    t_hold();
    t_inhibit_hold();
    t_inhibit_load();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule